// File: doc/BRIEF.md
# Sample-Capture Burst Write Engine

This block moves a fixed-length block of samples from a streaming source into system memory without processor involvement. Software programs a destination byte address, a length counted in data beats and a source choice through a small AXI4-Lite register slave, then sets a start bit. The engine fills an internal FIFO from the chosen stream and writes the samples out as AXI4 INCR bursts. Software polls a status register until the transfer is reported complete, then reads the written region.

The register slave runs on its own clock. The capture FIFO, the burst sequencer and the AXI4 write master run on a second, independent clock. Start crosses into the master domain as a toggle. Busy, completion and error cross back through two-flop synchronizers. Configuration registers are frozen while a transfer is in flight, so the master side can sample them directly. The master decodes no address range of its own and writes wherever the programmed address points.

Top module: `burst_capture_master`

## Requirements
- R1: After reset the status register (offset 0xC) reads 0, the control register (offset 0x0) reads 0, and no AW or W valid is driven.
- R2: Offset 0x4 holds the destination byte address and offset 0x8 the length in 32-bit beats; both read back what was written. Control bit 1 (source select) reads back, while control bit 0 (start) always reads 0.
- R3: Writing 1 to control bit 0 sets status bit 0 (busy) immediately. While busy, writes to offsets 0x0, 0x4 and 0x8 are ignored.
- R4: Every write burst is INCR (AWBURST=01) with AWSIZE=2 and at most 16 beats. Bursts follow one another at consecutive addresses, and AW outputs hold steady until accepted.
- R5: No burst crosses a 4096-byte address boundary; a transfer that would cross one is split there.
- R6: A burst's address is issued only once the FIFO holds every beat of that burst, so W valid never drops inside a burst. WLAST marks exactly the final beat, and a new AW is issued only after the previous write response has been accepted.
- R7: Beats are written in arrival order from the source picked by control bit 1 (0 = source 0, 1 = source 1). The unselected source never sees ready, and exactly the programmed number of samples is taken.
- R8: On completion status bit 1 (done) is set and busy clears. Writing 1 to status bit 1 clears done and error.
- R9: A non-OKAY write response sets status bit 2 (error), and the transfer still completes with done. If no response arrives within RESP_TIMEOUT master cycles, the engine sets error and done and still accepts a later start.
- R10: A start with length 0 sets done without issuing any write address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Register slave clock |
| s_rst_n | input | 1 | Synchronous active-low reset, slave domain |
| s_awaddr | input | 4 | Lite write address |
| s_awvalid | input | 1 | Lite write address valid |
| s_awready | output | 1 | Lite write address ready |
| s_wdata | input | 32 | Lite write data |
| s_wvalid | input | 1 | Lite write data valid |
| s_wready | output | 1 | Lite write data ready |
| s_bresp | output | 2 | Lite write response (always OKAY) |
| s_bvalid | output | 1 | Lite write response valid |
| s_bready | input | 1 | Lite write response ready |
| s_araddr | input | 4 | Lite read address |
| s_arvalid | input | 1 | Lite read address valid |
| s_arready | output | 1 | Lite read address ready |
| s_rdata | output | 32 | Lite read data |
| s_rresp | output | 2 | Lite read response (always OKAY) |
| s_rvalid | output | 1 | Lite read data valid |
| s_rready | input | 1 | Lite read data ready |
| m_clk | input | 1 | Master-side clock |
| m_rst_n | input | 1 | Synchronous active-low reset, master domain |
| src_data | input | 64 | Sample words, source 0 in the low 32 bits |
| src_valid | input | 2 | Sample valid per source |
| src_ready | output | 2 | Sample ready per source |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The bench drives the two clocks at unrelated periods and throttles the sample stream, so an engine that issues an address before its data is buffered shows up as W-valid bubbles inside a burst or as zero-filled beats. A transfer starting 32 bytes below a 4 KB line shows whether the split happens at the boundary rather than at a fixed 16-beat stride. A withheld write response tests that the engine frees itself with error set instead of hanging, and a rerun afterwards proves a new start is still taken. Writes to address, length and select during a busy transfer, a zero-length start and a non-OKAY response catch a register file that does not freeze, a sequencer that emits an empty burst, and an error bit that is dropped in the crossing.

// File: rtl/bcm_pkg.sv
// Shared constants and types for the sample-capture burst write engine.
// Assumes a 32-bit lite register bus and AXI4 encodings for burst type and response.
package bcm_pkg;
    localparam int REG_W = 32;
    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int PAGE_BYTES = 4096;

    // Register offsets, decoded on address bits [3:2].
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_DEST = 2'd1;
    localparam logic [1:0] REG_LEN  = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_ADDR,
        ST_DATA,
        ST_RESP,
        ST_FINISH
    } eng_state_t;
endpackage

// File: rtl/bcm_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit into the destination clock.
// Assumes each bit is a level or a toggle that changes far slower than the clock.
module bcm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bcm_regs.sv
// Lite register slave in the slave clock domain: destination, length, control and status.
// Assumes single-beat lite accesses; config is frozen while busy so the master side may read it directly.
module bcm_regs
    import bcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEL_W  = 1,
    parameter int RA_W   = 4
) (
    input  logic              s_clk,
    input  logic              s_rst_n,
    input  logic [RA_W-1:0]   awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [RA_W-1:0]   araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [REG_W-1:0]  rdata,
    output logic              rvalid,
    input  logic              rready,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [LEN_W-1:0]  cfg_len,
    output logic [SEL_W-1:0]  cfg_sel,
    output logic              start_tgl,
    input  logic              busy_sync,
    input  logic              done_tgl_sync,
    input  logic              err_sync
);
    logic wr_fire, rd_fire, done_evt;
    logic busy_q, done_q, err_q, tgl_prev;
    logic [1:0] wsel, rsel;

    assign wr_fire  = awvalid && wvalid && !bvalid;
    assign awready  = wr_fire;
    assign wready   = wr_fire;
    assign rd_fire  = arvalid && !rvalid;
    assign arready  = !rvalid;
    assign wsel     = awaddr[3:2];
    assign rsel     = araddr[3:2];
    assign done_evt = tgl_prev != done_tgl_sync;

    // Write response channel handshake.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n)          bvalid <= 1'b0;
        else if (wr_fire)      bvalid <= 1'b1;
        else if (bready)       bvalid <= 1'b0;
    end

    // Track the synchronized completion toggle for edge detection.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) tgl_prev <= 1'b0;
        else          tgl_prev <= done_tgl_sync;
    end

    // Configuration, start toggle and sticky status updates.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            cfg_addr  <= '0;
            cfg_len   <= '0;
            cfg_sel   <= '0;
            start_tgl <= 1'b0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if (wr_fire) begin
                case (wsel)
                    REG_CTRL: if (!busy_q) begin
                        cfg_sel <= wdata[1 +: SEL_W];
                        if (wdata[0]) begin
                            start_tgl <= !start_tgl;
                            busy_q    <= 1'b1;
                            done_q    <= 1'b0;
                            err_q     <= 1'b0;
                        end
                    end
                    REG_DEST: if (!busy_q) cfg_addr <= wdata[ADDR_W-1:0];
                    REG_LEN:  if (!busy_q) cfg_len  <= wdata[LEN_W-1:0];
                    default:  if (wdata[1]) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                endcase
            end
            if (done_evt) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
                err_q  <= err_sync;
            end
        end
    end

    // Registered read data path.
    always_ff @(posedge s_clk) begin
        if (!s_rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (rd_fire) begin
            rvalid <= 1'b1;
            case (rsel)
                REG_CTRL: rdata <= REG_W'({cfg_sel, 1'b0});
                REG_DEST: rdata <= REG_W'(cfg_addr);
                REG_LEN:  rdata <= REG_W'(cfg_len);
                default:  rdata <= REG_W'({err_q, done_q, busy_q});
            endcase
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R3: configuration must not move during a transfer.
    assert_cfg_frozen_R3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        (busy_q && $past(busy_q)) |-> ($stable(cfg_addr) && $stable(cfg_len) && $stable(cfg_sel)));
    // R8: engine busy seen from the master side implies local busy is still set.
    assert_busy_cover_R8: assert property (@(posedge s_clk) disable iff (!s_rst_n)
        busy_sync |-> busy_q);
endmodule

// File: rtl/bcm_fifo.sv
// Show-ahead synchronous sample FIFO in the master domain with occupancy count and flush.
// Assumes the writer never pushes when full and the reader never pops when empty.
module bcm_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    assign empty = count == '0;
    assign full  = count == CW'(DEPTH);
    assign dout  = mem[rd_ptr];

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy maintenance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R7: a sample is never written into a full FIFO.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R6: a beat is never taken from an empty FIFO.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/bcm_engine.sv
// Burst sequencer in the master domain: capture accounting, burst sizing, AW/W/B sequencing.
// Assumes FIFO depth of at least MAX_BURST and a destination aligned to the beat size.
module bcm_engine
    import bcm_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int LEN_W        = 16,
    parameter int MAX_BURST    = 16,
    parameter int CNT_W        = 6,
    parameter int RESP_TIMEOUT = 1024,
    localparam int BYTES       = DATA_W / 8,
    localparam int SIZE        = $clog2(BYTES),
    localparam int TMO_W       = $clog2(RESP_TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    input  logic              pushed,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic              cap_en,
    output logic [ADDR_W-1:0] awaddr,
    output logic [7:0]        awlen,
    output logic              awvalid,
    input  logic              awready,
    output logic              wvalid,
    output logic              wlast,
    input  logic              wready,
    input  logic [1:0]        bresp,
    input  logic              bvalid,
    output logic              bready,
    output logic              busy,
    output logic              done_tgl,
    output logic              err
);
    eng_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain, cap_left;
    logic [7:0]        blen, beat;
    logic [TMO_W-1:0]  timer;
    logic [12:0]       room_beats;
    logic [LEN_W:0]    lim;

    // Size the next burst: capped by maximum length, remaining beats and the 4 KB line.
    always_comb begin
        room_beats = (13'(PAGE_BYTES) - {1'b0, cur_addr[11:0]}) >> SIZE;
        lim = (LEN_W+1)'(MAX_BURST);
        if ({1'b0, remain} < lim) lim = {1'b0, remain};
        if ((LEN_W+1)'(room_beats) < lim) lim = (LEN_W+1)'(room_beats);
    end

    assign awaddr     = cur_addr;
    assign awlen      = blen;
    assign awvalid    = state == ST_ADDR;
    assign wvalid     = (state == ST_DATA) && !fifo_empty;
    assign wlast      = beat == blen;
    assign fifo_pop   = wvalid && wready;
    assign bready     = state == ST_RESP;
    assign cap_en     = busy && (cap_left != '0);
    assign fifo_flush = (state == ST_IDLE) && start;

    // Count samples still to be captured for this transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cap_left <= '0;
        else if ((state == ST_IDLE) && start) cap_left <= cfg_len;
        else if (state == ST_FINISH)          cap_left <= '0;
        else if (pushed)                      cap_left <= cap_left - 1'b1;
    end

    // Main transfer state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            blen     <= '0;
            beat     <= '0;
            timer    <= '0;
            busy     <= 1'b0;
            done_tgl <= 1'b0;
            err      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur_addr <= cfg_addr & ~ADDR_W'(BYTES - 1);
                    remain   <= cfg_len;
                    busy     <= 1'b1;
                    err      <= 1'b0;
                    state    <= (cfg_len == '0) ? ST_FINISH : ST_FILL;
                end
                ST_FILL: if ((LEN_W+1)'(fifo_count) >= lim) begin
                    blen  <= 8'(lim - 1'b1);
                    state <= ST_ADDR;
                end
                ST_ADDR: if (awready) begin
                    beat  <= '0;
                    state <= ST_DATA;
                end
                ST_DATA: if (fifo_pop) begin
                    beat <= beat + 1'b1;
                    if (wlast) begin
                        cur_addr <= cur_addr + ((ADDR_W'(blen) + ADDR_W'(1)) << SIZE);
                        remain   <= remain - (LEN_W'(blen) + LEN_W'(1));
                        timer    <= '0;
                        state    <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    timer <= timer + 1'b1;
                    if (bvalid) begin
                        if (bresp != RESP_OKAY) err <= 1'b1;
                        state <= (remain == '0) ? ST_FINISH : ST_FILL;
                    end else if (timer == TMO_W'(RESP_TIMEOUT - 1)) begin
                        err   <= 1'b1;
                        state <= ST_FINISH;
                    end
                end
                default: begin
                    busy     <= 1'b0;
                    done_tgl <= !done_tgl;
                    state    <= ST_IDLE;
                end
            endcase
        end
    end

    // R4: burst length never exceeds the maximum.
    assert_max_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (awlen <= 8'(MAX_BURST - 1)));
    // R4: address channel holds steady until accepted.
    assert_aw_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (awvalid && !awready) |=> (awvalid && $stable(awaddr) && $stable(awlen)));
    // R5: burst stays inside one 4 KB line.
    assert_no_page_cross_R5: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid |-> (({1'b0, awaddr[11:0]} + ((13'(awlen) + 13'd1) << SIZE)) <= 13'(PAGE_BYTES)));
    // R6: the data phase only runs with buffered samples available.
    assert_data_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> !fifo_empty);
    // R6: no new address while a response is pending.
    assert_aw_after_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bready |-> !awvalid && !wvalid);
endmodule

// File: rtl/burst_capture_master.sv
// Top: lite register slave (s_clk) plus capture FIFO and AXI4 burst write master (m_clk).
// Assumes s_clk and m_clk are unrelated; only synchronized toggles and levels cross, config is quasi-static.
module burst_capture_master
    import bcm_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int LEN_W        = 16,
    parameter int NUM_SRC      = 2,
    parameter int MAX_BURST    = 16,
    parameter int FIFO_DEPTH   = 32,
    parameter int RESP_TIMEOUT = 1024,
    localparam int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CNT_W       = $clog2(FIFO_DEPTH) + 1,
    localparam int SIZE        = $clog2(DATA_W / 8)
) (
    input  logic                      s_clk,
    input  logic                      s_rst_n,
    input  logic [3:0]                s_awaddr,
    input  logic                      s_awvalid,
    output logic                      s_awready,
    input  logic [31:0]               s_wdata,
    input  logic                      s_wvalid,
    output logic                      s_wready,
    output logic [1:0]                s_bresp,
    output logic                      s_bvalid,
    input  logic                      s_bready,
    input  logic [3:0]                s_araddr,
    input  logic                      s_arvalid,
    output logic                      s_arready,
    output logic [31:0]               s_rdata,
    output logic [1:0]                s_rresp,
    output logic                      s_rvalid,
    input  logic                      s_rready,
    input  logic                      m_clk,
    input  logic                      m_rst_n,
    input  logic [NUM_SRC*DATA_W-1:0] src_data,
    input  logic [NUM_SRC-1:0]        src_valid,
    output logic [NUM_SRC-1:0]        src_ready,
    output logic [ADDR_W-1:0]         m_awaddr,
    output logic [7:0]                m_awlen,
    output logic [2:0]                m_awsize,
    output logic [1:0]                m_awburst,
    output logic                      m_awvalid,
    input  logic                      m_awready,
    output logic [DATA_W-1:0]         m_wdata,
    output logic [DATA_W/8-1:0]       m_wstrb,
    output logic                      m_wlast,
    output logic                      m_wvalid,
    input  logic                      m_wready,
    input  logic [1:0]                m_bresp,
    input  logic                      m_bvalid,
    output logic                      m_bready
);
    logic [ADDR_W-1:0] cfg_addr;
    logic [LEN_W-1:0]  cfg_len;
    logic [SEL_W-1:0]  cfg_sel, m_sel;
    logic              start_tgl, start_sync, start_prev, start_pulse;
    logic              eng_busy, eng_done_tgl, eng_err;
    logic [2:0]        stat_sync;
    logic              cap_en, cap_ready, push, pop, flush, f_empty, f_full;
    logic [CNT_W-1:0]  f_count;
    logic [DATA_W-1:0] push_data;

    assign s_bresp   = RESP_OKAY;
    assign s_rresp   = RESP_OKAY;
    assign m_awsize  = 3'(SIZE);
    assign m_awburst = BURST_INCR;
    assign m_wstrb   = '1;

    bcm_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEL_W(SEL_W), .RA_W(4)) u_regs (
        .s_clk(s_clk), .s_rst_n(s_rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
        .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_sel(cfg_sel),
        .start_tgl(start_tgl),
        .busy_sync(stat_sync[0]), .done_tgl_sync(stat_sync[1]), .err_sync(stat_sync[2])
    );

    // Status back into the slave domain.
    bcm_sync #(.W(3), .STAGES(2)) u_sync_stat (
        .clk(s_clk), .rst_n(s_rst_n),
        .d({eng_err, eng_done_tgl, eng_busy}), .q(stat_sync)
    );

    // Start toggle into the master domain.
    bcm_sync #(.W(1), .STAGES(2)) u_sync_start (
        .clk(m_clk), .rst_n(m_rst_n), .d(start_tgl), .q(start_sync)
    );

    // Edge-detect the start toggle and latch the source choice with it.
    always_ff @(posedge m_clk) begin
        if (!m_rst_n) begin
            start_prev <= 1'b0;
            m_sel      <= '0;
        end else begin
            start_prev <= start_sync;
            if (start_pulse) m_sel <= cfg_sel;
        end
    end
    assign start_pulse = start_sync != start_prev;

    // Source multiplexer: only the selected stream is granted.
    assign cap_ready = cap_en && !f_full;
    assign push      = cap_ready && src_valid[m_sel];
    assign push_data = src_data[m_sel*DATA_W +: DATA_W];
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ready
        assign src_ready[g] = cap_ready && (m_sel == SEL_W'(g));
    end

    bcm_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(m_clk), .rst_n(m_rst_n), .flush(flush),
        .push(push), .din(push_data), .pop(pop), .dout(m_wdata),
        .empty(f_empty), .full(f_full), .count(f_count)
    );

    bcm_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST),
        .CNT_W(CNT_W), .RESP_TIMEOUT(RESP_TIMEOUT)
    ) u_engine (
        .clk(m_clk), .rst_n(m_rst_n), .start(start_pulse),
        .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .fifo_count(f_count), .fifo_empty(f_empty), .pushed(push),
        .fifo_pop(pop), .fifo_flush(flush), .cap_en(cap_en),
        .awaddr(m_awaddr), .awlen(m_awlen), .awvalid(m_awvalid), .awready(m_awready),
        .wvalid(m_wvalid), .wlast(m_wlast), .wready(m_wready),
        .bresp(m_bresp), .bvalid(m_bvalid), .bready(m_bready),
        .busy(eng_busy), .done_tgl(eng_done_tgl), .err(eng_err)
    );

    // R7: at most one source is granted at any time.
    assert_one_source_R7: assert property (@(posedge m_clk) disable iff (!m_rst_n)
        $onehot0(src_ready));
endmodule

// File: tb/burst_capture_master_tb.sv
// Directed bench: lite register tasks on s_clk, memory slave and sample sources on m_clk.
module burst_capture_master_tb;
    localparam int NS = 2;
    localparam int DW = 32;

    logic s_clk = 0, m_clk = 0, s_rst_n = 0, m_rst_n = 0;
    always #5 s_clk = ~s_clk;
    always #3.5 m_clk = ~m_clk;

    logic [3:0]  s_awaddr = 0, s_araddr = 0;
    logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
    logic [31:0] s_wdata = 0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;

    logic [NS*DW-1:0] src_data;
    logic [NS-1:0]    src_valid = 0, src_ready;
    logic [31:0] m_awaddr, m_wdata;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst, m_bresp = 0;
    logic [3:0]  m_wstrb;
    logic        m_awvalid, m_awready = 0, m_wlast, m_wvalid, m_wready = 0;
    logic        m_bvalid = 0, m_bready;

    burst_capture_master u_dut (.*);

    int n_chk = 0, n_fail = 0;
    int aw_cnt, w_cnt, bad_last, bad_attr, bubble, overlap;
    int aw_addr [64];
    int aw_len  [64];
    logic [31:0] wbeat [512];
    int src_cnt [NS];
    int rdy_seen [NS];
    logic [1:0] resp_mode = 0;
    bit drop_b = 0, b_pend = 0, in_data = 0;
    int cur_len = 0, beat_i = 0, b_delay = 0, tick = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Sample sources: count handshakes at negedge, present next word after the edge.
    initial begin
        for (int k = 0; k < NS; k++) begin src_cnt[k] = 0; rdy_seen[k] = 0; end
        src_data = {32'hB000_0000, 32'hA000_0000};
        forever begin
            @(negedge m_clk);
            for (int k = 0; k < NS; k++) begin
                if (src_ready[k]) rdy_seen[k]++;
                if (src_valid[k] && src_ready[k]) src_cnt[k]++;
            end
            @(posedge m_clk); #1;
            tick++;
            for (int k = 0; k < NS; k++) begin
                src_valid[k] = (tick % 4) != 3;
                src_data[k*DW +: DW] = (k == 0 ? 32'hA000_0000 : 32'hB000_0000) + 32'(src_cnt[k]);
            end
        end
    end

    // Memory slave model with throttled ready and delayed responses.
    initial begin
        forever begin
            bit aw_hs, w_hs, b_hs;
            @(negedge m_clk);
            aw_hs = m_awvalid && m_awready;
            w_hs  = m_wvalid && m_wready;
            b_hs  = m_bvalid && m_bready;
            if (m_awvalid && (in_data || b_pend)) overlap++;
            if (in_data && m_wready && !m_wvalid) bubble++;
            if (aw_hs) begin
                if (aw_cnt < 64) begin aw_addr[aw_cnt] = int'(m_awaddr); aw_len[aw_cnt] = int'(m_awlen); end
                if (m_awsize != 3'd2 || m_awburst != 2'b01) bad_attr++;
                aw_cnt++; cur_len = int'(m_awlen); beat_i = 0; in_data = 1;
            end else if (w_hs) begin
                if (w_cnt < 512) wbeat[w_cnt] = m_wdata;
                w_cnt++;
                if (m_wlast != (beat_i == cur_len)) bad_last++;
                beat_i++;
                if (m_wlast) begin in_data = 0; b_pend = 1; b_delay = 3; end
            end
            if (b_hs) b_pend = 0;
            @(posedge m_clk); #1;
            m_awready = tick[0];
            m_wready  = (tick % 5) != 4;
            if (b_hs) m_bvalid = 0;
            else if (b_pend && !m_bvalid && !drop_b) begin
                if (b_delay == 0) begin m_bvalid = 1; m_bresp = resp_mode; end
                else b_delay--;
            end
        end
    end

    task automatic lite_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge s_clk); #1;
        s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
        do @(negedge s_clk); while (!s_awready);
        @(posedge s_clk); #1;
        s_awvalid = 0; s_wvalid = 0; s_bready = 1;
        do @(negedge s_clk); while (!s_bvalid);
        @(posedge s_clk); #1;
        s_bready = 0;
    endtask

    task automatic lite_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge s_clk); #1;
        s_araddr = a; s_arvalid = 1;
        do @(negedge s_clk); while (!s_arready);
        @(posedge s_clk); #1;
        s_arvalid = 0; s_rready = 1;
        do @(negedge s_clk); while (!s_rvalid);
        d = s_rdata;
        @(posedge s_clk); #1;
        s_rready = 0;
    endtask

    task automatic clear_model();
        aw_cnt = 0; w_cnt = 0; bad_last = 0; bad_attr = 0; bubble = 0; overlap = 0;
        b_pend = 0; in_data = 0;
        for (int k = 0; k < NS; k++) begin src_cnt[k] = 0; rdy_seen[k] = 0; end
    endtask

    task automatic launch(input logic [31:0] addr, input logic [31:0] len, input int sel);
        clear_model();
        lite_wr(4'h4, addr);
        lite_wr(4'h8, len);
        lite_wr(4'h0, 32'(sel << 1) | 32'h1);
    endtask

    task automatic wait_done(output logic [31:0] st);
        st = 0;
        for (int i = 0; i < 3000; i++) begin
            lite_rd(4'hC, st);
            if (st[1]) break;
        end
    endtask

    task automatic check_bursts(input int addr, input int len, input string tag);
        int a = addr, rem = len, i = 0, errs = 0;
        while (rem > 0) begin
            int n = 16;
            int room = (4096 - (a % 4096)) / 4;
            if (rem < n) n = rem;
            if (room < n) n = room;
            if (i >= aw_cnt || aw_addr[i] != a || aw_len[i] != n - 1) errs++;
            a += n * 4; rem -= n; i++;
        end
        chk(errs == 0 && aw_cnt == i, tag, aw_cnt, i);
    endtask

    task automatic check_data(input logic [31:0] base, input int len, input string tag);
        int errs = 0;
        for (int j = 0; j < len; j++) if (wbeat[j] != base + 32'(j)) errs++;
        chk(errs == 0 && w_cnt == len, tag, w_cnt, len);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        lite_rd(4'hC, d); chk(d == 0, "R1 status after reset", d, 0);
        lite_rd(4'h0, d); chk(d == 0, "R1 control after reset", d, 0);
        chk(!m_awvalid && !m_wvalid, "R1 master idle", {m_awvalid, m_wvalid}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        lite_wr(4'h4, 32'h1234_5670); lite_wr(4'h8, 32'h0000_0123); lite_wr(4'h0, 32'h2);
        lite_rd(4'h4, d); chk(d == 32'h1234_5670, "R2 dest readback", d, 32'h1234_5670);
        lite_rd(4'h8, d); chk(d == 32'h123, "R2 length readback", d, 32'h123);
        lite_rd(4'h0, d); chk(d == 32'h2, "R2 control readback", d, 2);
        lite_wr(4'h0, 32'h0);
    endtask

    task automatic t_main();
        logic [31:0] d;
        launch(32'h1000, 40, 0);
        lite_rd(4'hC, d); chk(d[0] == 1, "R3 busy after start", d, 1);
        lite_wr(4'h4, 32'h5000); lite_wr(4'h8, 32'h7); lite_wr(4'h0, 32'h2);
        lite_rd(4'h4, d); chk(d == 32'h1000, "R3 dest frozen", d, 32'h1000);
        lite_rd(4'h8, d); chk(d == 40, "R3 length frozen", d, 40);
        lite_rd(4'h0, d); chk(d == 0, "R3 select frozen", d, 0);
        wait_done(d);
        chk(d == 32'h2, "R8 status done", d, 2);
        check_bursts(32'h1000, 40, "R4 burst split 16/16/8");
        chk(bad_attr == 0, "R4 size and type", bad_attr, 0);
        check_data(32'hA000_0000, 40, "R7 source 0 data order");
        chk(bubble == 0, "R6 no W bubble inside burst", bubble, 0);
        chk(overlap == 0, "R6 AW waits for B", overlap, 0);
        chk(bad_last == 0, "R6 WLAST placement", bad_last, 0);
        chk(src_cnt[0] == 40, "R7 exact sample count", src_cnt[0], 40);
        lite_wr(4'hC, 32'h2);
        lite_rd(4'hC, d); chk(d == 0, "R8 done cleared by W1C", d, 0);
    endtask

    task automatic t_page();
        logic [31:0] d;
        launch(32'h1FE0, 20, 0);
        wait_done(d);
        check_bursts(32'h1FE0, 20, "R5 split at 4 KB line");
        chk(aw_cnt == 2 && aw_len[0] == 7 && aw_len[1] == 11, "R5 burst lengths 8 and 12", aw_len[0], 7);
        check_data(32'hA000_0000, 20, "R5 data across split");
        lite_wr(4'hC, 32'h2);
    endtask

    task automatic t_src1();
        logic [31:0] d;
        launch(32'h8000, 20, 1);
        wait_done(d);
        check_data(32'hB000_0000, 20, "R7 source 1 data");
        chk(rdy_seen[0] == 0, "R7 unselected source never ready", rdy_seen[0], 0);
        check_bursts(32'h8000, 20, "R4 bursts on source 1");
        lite_wr(4'hC, 32'h2);
    endtask

    task automatic t_err();
        logic [31:0] d;
        resp_mode = 2'b10;
        launch(32'h3000, 8, 0);
        wait_done(d);
        chk(d == 32'h6, "R9 error on bad response", d, 6);
        resp_mode = 2'b00;
        lite_wr(4'hC, 32'h2);
        lite_rd(4'hC, d); chk(d == 0, "R8 W1C clears error", d, 0);
    endtask

    task automatic t_timeout();
        logic [31:0] d;
        drop_b = 1;
        launch(32'h4000, 4, 0);
        wait_done(d);
        chk(d == 32'h6, "R9 timeout sets error and done", d, 6);
        drop_b = 0;
        lite_wr(4'hC, 32'h2);
        launch(32'h4100, 4, 0);
        wait_done(d);
        chk(d == 32'h2, "R9 restart after timeout", d, 2);
        check_data(32'hA000_0000, 4, "R9 restart data");
        lite_wr(4'hC, 32'h2);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        launch(32'h5000, 0, 0);
        wait_done(d);
        chk(d == 32'h2, "R10 zero length done", d, 2);
        chk(aw_cnt == 0, "R10 no address issued", aw_cnt, 0);
        lite_wr(4'hC, 32'h2);
    endtask

    initial begin
        #1000000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        clear_model();
        repeat (5) @(posedge s_clk);
        #1; s_rst_n = 1; m_rst_n = 1;
        repeat (3) @(posedge s_clk);
        t_reset();
        t_regs();
        t_main();
        t_page();
        t_src1();
        t_err();
        t_timeout();
        t_zero();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule